// File: doc/BRIEF.md
# Atomic-Update GPIO Port

This block is a bank of general-purpose pins, one bit per pin in every register, reached over a simple word-addressed bus with separate write and read strobes. Software drives pins through an output level register and chooses which pins actually drive through a drive-enable register; a read-only register returns the pin levels after a two-flop synchronizer.

Next to the plain level register sit three write-only "atomic" registers. A 1 in the written word raises, drops or inverts the matching output bit, and a 0 leaves it alone. Software can therefore change single pins without a read-modify-write sequence, and no other agent's update is lost.

Writes take effect at the clock edge that samples the write strobe. Reads are combinational from the address and read strobe. The word address must be at least 3 bits wide. Register words: 0 level, 1 raise, 2 drop, 3 invert, 4 sensed input, 5 drive enable; all other words are unmapped.

Top module: `pio_bank`

## Requirements
- R1: A synchronous active-high reset clears the output level and drive-enable registers, so after reset `pin_out` and `pin_oe` are all 0 and words 0 and 5 read 0.
- R2: A write to word 0 loads the output level register with `bus_wdata` at that clock edge; a read of word 0 returns the register and `pin_out` follows it.
- R3: A write to word 1 sets every output level bit whose written bit is 1 and leaves every other bit unchanged.
- R4: A write to word 2 clears every output level bit whose written bit is 1 and leaves every other bit unchanged.
- R5: A write to word 3 inverts every output level bit whose written bit is 1 and leaves every other bit unchanged.
- R6: A write to word 5 loads the drive-enable register (1 = pin drives, 0 = pin is an input); reads of word 5 return it and `pin_oe` equals it bit for bit.
- R7: A read of word 4 returns `pin_in` as sampled two clock edges earlier (two-flop synchronizer, cleared by reset); writes to word 4 change no register.
- R8: Reads of words 1, 2 and 3 return 0.
- R9: Words 6 and 7 (and any word with a nonzero bit above bit 2) read 0, and writes to them change neither `pin_out` nor `pin_oe`.
- R10: `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_re | input | 1 | Read strobe, gates `bus_rdata` |
| bus_addr | input | AW | Word address |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, combinational |
| pin_in | input | N | Asynchronous pin levels |
| pin_out | output | N | Output level per pin |
| pin_oe | output | N | Drive enable per pin |

## Verification
The bench covers the atomic words with masks that overlap bits already set and already clear. A design that treated a 0 as "write 0" would corrupt the untouched bits, and one that swapped the raise and drop words would miss the expected pattern. It steps the pin inputs and reads word 4 on each following cycle, which catches a synchronizer with one stage or three stages. Writes to word 4 and to the unmapped words, followed by readback and pin checks, expose a loose decode that aliases words. Reads of the atomic words and reads with the strobe low expose a read mux that leaks register contents.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_LEVEL = 3'd0,
        RG_RAISE = 3'd1,
        RG_DROP  = 3'd2,
        RG_FLIP  = 3'd3,
        RG_SENSE = 3'd4,
        RG_DRIVE = 3'd5,
        RG_VOID6 = 3'd6,
        RG_VOID7 = 3'd7
    } pio_reg_e;

    typedef enum logic [1:0] {
        RS_ZERO  = 2'd0,
        RS_LEVEL = 2'd1,
        RS_SENSE = 2'd2,
        RS_DRIVE = 2'd3
    } pio_rsel_e;

    typedef struct packed {
        logic ld_level;
        logic raise;
        logic drop;
        logic flip;
        logic ld_drive;
    } pio_wr_t;

    function automatic pio_wr_t wr_decode(input logic we, input pio_reg_e r);
        pio_wr_t w;
        w = '0;
        if (we) begin
            unique case (r)
                RG_LEVEL: w.ld_level = 1'b1;
                RG_RAISE: w.raise    = 1'b1;
                RG_DROP:  w.drop     = 1'b1;
                RG_FLIP:  w.flip     = 1'b1;
                RG_DRIVE: w.ld_drive = 1'b1;
                default:  w = '0;
            endcase
        end
        return w;
    endfunction

    function automatic pio_rsel_e rd_decode(input logic re, input pio_reg_e r);
        pio_rsel_e s;
        s = RS_ZERO;
        if (re) begin
            unique case (r)
                RG_LEVEL: s = RS_LEVEL;
                RG_SENSE: s = RS_SENSE;
                RG_DRIVE: s = RS_DRIVE;
                default:  s = RS_ZERO;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    output pio_wr_t       wr,
    output pio_rsel_e     rsel
);

    logic     hi_zero;
    pio_reg_e idx;

    generate
        if (AW > REG_IDX_W) begin : g_wide
            assign hi_zero = (addr[AW-1:REG_IDX_W] == '0);
        end else begin : g_narrow
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        idx = hi_zero ? pio_reg_e'(addr[REG_IDX_W-1:0]) : RG_VOID7;
    end

    always_comb begin
        wr   = wr_decode(we, idx);
        rsel = rd_decode(re, idx);
    end

endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  pio_wr_t      wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] level_q,
    output logic [N-1:0] drive_q
);

    logic [N-1:0] level_d;
    logic [N-1:0] drive_d;

    always_comb begin
        level_d = level_q;
        unique case (1'b1)
            wr.ld_level: level_d = wdata;
            wr.raise:    level_d = level_q | wdata;
            wr.drop:     level_d = level_q & ~wdata;
            wr.flip:     level_d = level_q ^ wdata;
            default:     level_d = level_q;
        endcase
    end

    always_comb begin
        drive_d = wr.ld_drive ? wdata : drive_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            drive_q <= '0;
        end else begin
            level_q <= level_d;
            drive_q <= drive_d;
        end
    end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  pio_rsel_e    rsel,
    input  logic [N-1:0] level_q,
    input  logic [N-1:0] drive_q,
    input  logic [N-1:0] sense,
    output logic [N-1:0] rdata
);

    always_comb begin
        unique case (rsel)
            RS_LEVEL: rdata = level_q;
            RS_SENSE: rdata = sense;
            RS_DRIVE: rdata = drive_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe
);

    localparam int unsigned SYNC_STAGES = 2;

    pio_wr_t      wr;
    pio_rsel_e    rsel;
    logic [N-1:0] level_q;
    logic [N-1:0] drive_q;
    logic [N-1:0] sense;

    pio_decode #(.AW(AW)) u_dec (
        .we   (bus_we),
        .re   (bus_re),
        .addr (bus_addr),
        .wr   (wr),
        .rsel (rsel)
    );

    pio_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wdata   (bus_wdata),
        .level_q (level_q),
        .drive_q (drive_q)
    );

    pio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sense)
    );

    pio_rdmux #(.N(N)) u_rd (
        .rsel    (rsel),
        .level_q (level_q),
        .drive_q (drive_q),
        .sense   (sense),
        .rdata   (bus_rdata)
    );

    assign pin_out = level_q;
    assign pin_oe  = drive_q;

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic          bus_re,
    input logic [AW-1:0] bus_addr,
    input logic [N-1:0]  bus_wdata,
    input logic [N-1:0]  bus_rdata,
    input logic [N-1:0]  pin_in,
    input logic [N-1:0]  pin_out,
    input logic [N-1:0]  pin_oe
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |-> (pin_out == '0 && pin_oe == '0)); // R1

    AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(0)) |=> pin_out == $past(bus_wdata)); // R2

    AST_RAISE_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(1)) |=>
            pin_out == ($past(pin_out) | $past(bus_wdata))); // R3

    AST_DROP_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(2)) |=>
            pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R4

    AST_FLIP_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(3)) |=>
            pin_out == ($past(pin_out) ^ $past(bus_wdata))); // R5

    AST_DRIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(5)) |=> pin_oe == $past(bus_wdata)); // R6

    AST_SENSE_DELAY: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == AW'(4) && since_rst == 2'd2) |->
            bus_rdata == $past(pin_in, 2)); // R7

    AST_ATOMIC_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (bus_addr == AW'(1) || bus_addr == AW'(2) || bus_addr == AW'(3)))
            |-> bus_rdata == '0); // R8

    AST_VOID_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr > AW'(5)) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == '0); // R10

endmodule

bind pio_bank pio_bank_chk #(.N(N), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_pio_bank.sv
`timescale 1ns/1ps
module sim_pio_bank;

    localparam int N  = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;

    always #2.5 clk = ~clk;

    pio_bank #(.N(N), .AW(AW)) u0 (
        .clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata,
        .bus_rdata, .pin_in, .pin_out, .pin_oe
    );

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference state
    logic [N-1:0] m_out = '0;
    logic [N-1:0] m_dir = '0;
    logic [N-1:0] m_hist [$];

    function automatic logic [N-1:0] m_sense();
        return (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : '0;
    endfunction

    function automatic logic [N-1:0] exp_rd(logic re, logic [AW-1:0] a);
        if (!re) return '0;
        case (int'(a))
            0:       return m_out;
            4:       return m_sense();
            5:       return m_dir;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_out = '0;
            m_dir = '0;
            m_hist.delete();
            m_hist.push_back('0);
            m_hist.push_back('0);
        end else begin
            m_hist.push_back(pin_in);
            if (m_hist.size() > 2) void'(m_hist.pop_front());
            if (bus_we) begin
                case (int'(bus_addr))
                    0: m_out = bus_wdata;
                    1: m_out = m_out | bus_wdata;
                    2: m_out = m_out & ~bus_wdata;
                    3: m_out = m_out ^ bus_wdata;
                    5: m_dir = bus_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(string tag, logic we, logic re, logic [AW-1:0] a,
                        logic [N-1:0] wd, logic [N-1:0] pin);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; pin_in = pin;
        #1;
        chk(tag, "rdata", bus_rdata, exp_rd(re, a));
        @(posedge clk);
        model_edge();
        #1;
        chk(tag, "pin_out", pin_out, m_out);
        chk(tag, "pin_oe", pin_oe, m_dir);
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        model_edge();
        // writes during reset have no effect (R1)
        step("R1", 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step("R1", 1'b1, 1'b1, 3'd5, 32'hFFFF_FFFF, 32'h1234_5678);
        rst = 1'b0;
        step("R1", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        step("R1", 1'b0, 1'b1, 3'd5, '0, 32'h0);

        // R2 full load and readback
        step("R2", 1'b1, 1'b0, 3'd0, 32'hA5A5_5A5A, 32'h0);
        step("R2", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        // R3 set with overlap; zero mask no change
        step("R3", 1'b1, 1'b0, 3'd1, 32'h0000_FFFF, 32'h0);
        step("R3", 1'b1, 1'b1, 3'd1, 32'h0, 32'h0);
        step("R2", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        // R4 clear with overlap
        step("R4", 1'b1, 1'b0, 3'd2, 32'hFF00_00FF, 32'h0);
        step("R4", 1'b1, 1'b1, 3'd2, 32'h0, 32'h0);
        step("R2", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        // R5 toggle twice returns to start
        step("R5", 1'b1, 1'b0, 3'd3, 32'hF0F0_F0F0, 32'h0);
        step("R5", 1'b1, 1'b1, 3'd3, 32'hF0F0_F0F0, 32'h0);
        step("R5", 1'b1, 1'b1, 3'd3, 32'h8000_0001, 32'h0);
        // R6 direction and output enable
        step("R6", 1'b1, 1'b0, 3'd5, 32'h0F0F_3C3C, 32'h0);
        step("R6", 1'b0, 1'b1, 3'd5, '0, 32'h0);
        // R7 synchronizer latency, pins change each cycle
        step("R7", 1'b0, 1'b1, 3'd4, '0, 32'hDEAD_BEEF);
        step("R7", 1'b0, 1'b1, 3'd4, '0, 32'h1357_9BDF);
        step("R7", 1'b0, 1'b1, 3'd4, '0, 32'h0000_0000);
        step("R7", 1'b0, 1'b1, 3'd4, '0, 32'hFFFF_0000);
        step("R7", 1'b1, 1'b1, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_0000);
        step("R7", 1'b0, 1'b1, 3'd0, '0, 32'hFFFF_0000);
        step("R7", 1'b0, 1'b1, 3'd5, '0, 32'hFFFF_0000);
        // R8 atomic words read zero
        step("R8", 1'b0, 1'b1, 3'd1, '0, 32'h0);
        step("R8", 1'b0, 1'b1, 3'd2, '0, 32'h0);
        step("R8", 1'b0, 1'b1, 3'd3, '0, 32'h0);
        // R9 unmapped words
        step("R9", 1'b1, 1'b1, 3'd6, 32'hFFFF_FFFF, 32'h0);
        step("R9", 1'b1, 1'b1, 3'd7, 32'h0000_0000, 32'h0);
        step("R9", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        step("R9", 1'b0, 1'b1, 3'd5, '0, 32'h0);
        // R10 read strobe low hides every register
        for (int a = 0; a < 8; a++) begin
            step("R10", 1'b0, 1'b0, 3'(a), '0, 32'hFFFF_FFFF);
        end
        // mixed traffic against the model (R2 R3 R4 R5 R6 R7 R9)
        for (int i = 0; i < 400; i++) begin
            step("R5", 1'($urandom()), 1'($urandom()), 3'($urandom()),
                 $urandom(), $urandom());
        end
        // mid-run reset clears state again (R1)
        rst = 1'b1;
        step("R1", 1'b1, 1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0);
        rst = 1'b0;
        step("R1", 1'b0, 1'b1, 3'd0, '0, 32'h0);
        step("R1", 1'b0, 1'b1, 3'd4, '0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule